// File: doc/BRIEF.md
# Grouped Dual-Channel DAC Latch Controller

This block decides when two DAC channels move their output codes. Each channel has a data register and a control register, both written over a simple one-cycle write bus. A write puts new data in the data register. The code that drives the converter is a separate output register. It loads from the bus or from the stored data, depending on the trigger chosen for that channel. There are three triggers: a data write that always loads, a data write that loads only while the channel is enabled, and the rising edge of an external timer pulse.

The two channels can be bound into a group. In that case one shared trigger moves both output codes on the same clock edge. A grouped update happens only when both channels are enabled and both data registers have been written since the last update. The converters, settling-time control and interrupt logic are outside this block. The block supplies the two output codes and a one-cycle update strobe per channel.

Top module: `dac_group_latch`

## Requirements
- R1: Address map: `wr_addr` 0 is channel 0 data, 1 is channel 0 control, 2 is channel 1 data and 3 is channel 1 control. A control word holds the enable in bit 0, the group bit in bit 1 and the load-select field in bits 3:2. Reset clears the data registers, control registers, pending flags, output codes and strobes to zero.
- R2: An ungrouped channel with load-select 0 loads the written bus value into its output code at the clock edge that samples the data write. The enable bit has no effect in this mode.
- R3: An ungrouped channel with load-select 1 loads the written value at that same edge only when its enable bit is 1. Otherwise the write changes only the stored data.
- R4: An ungrouped channel with load-select 2 or 3 loads its stored data at the edge that samples a rising edge of `tmr_trig`, provided its enable is 1. A trigger held high gives one update. A data write in the trigger cycle is not part of that update.
- R5: The channels are grouped exactly when channel 0's group bit is 1 and both load-select fields are nonzero. Channel 1's group bit has no effect. A control write takes effect in the cycle after it.
- R6: While grouped, channel 1's load-select picks the shared trigger: 1 selects a data write and 2 or 3 selects the timer rising edge. Channel 0's nonzero value plays no part.
- R7: While grouped with either enable at 0, neither output code changes and neither strobe asserts.
- R8: Each channel has a pending flag. A data write sets it, even when the value equals the old one. Any load of that channel clears it, unless a write that the load did not take lands in the same cycle.
- R9: In grouped write-trigger mode, the data write that leaves both flags set (counting itself) loads both codes on its edge. The written channel takes the bus value and the other channel takes its stored data.
- R10: In grouped timer mode, a rising edge of `tmr_trig` with both flags already set loads both stored data values. A rising edge seen with either flag clear is dropped, not held for later.
- R11: A channel's strobe is high for exactly the cycle after each edge that loads its code. A grouped load raises both strobes together, and an output code never changes without its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Write value; control words use bits 3:0 |
| tmr_trig | input | 1 | External timer trigger level, synchronous to clk |
| dac0_code | output | DATA_W | Channel 0 output code |
| dac1_code | output | DATA_W | Channel 1 output code |
| dac0_upd | output | 1 | Channel 0 load strobe |
| dac1_upd | output | 1 | Channel 1 load strobe |

## Verification
Each output code and strobe is due one register stage after its cause. It appears just after the rising edge that samples the write or the trigger rise. A control write only takes effect from the next cycle. The bench drives every input on the falling edge, updates its reference state for that same cycle, and compares all four outputs 1 ns after the following rising edge. The reset values are checked 1 ns after reset is asserted, with no clock edge in between. A sweep over all 256 pairs of control words runs the same write and trigger script for each pair. The script includes a dropped trigger, a held trigger, a rewrite of an unchanged value and a write that coincides with a trigger.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

  // Trigger choice per channel; values 2 and 3 both select the timer edge.
  typedef enum logic [1:0] {
    LSEL_IMM   = 2'd0,
    LSEL_WR    = 2'd1,
    LSEL_TMR   = 2'd2,
    LSEL_TMR_B = 2'd3
  } lsel_e;

  // Packed layout: [3:2] load-select, [1] group, [0] enable.
  typedef struct packed {
    lsel_e lsel;
    logic  grp;
    logic  en;
  } chan_ctrl_t;

  localparam int CTRL_W = 4;
  localparam int NCH    = 2;

endpackage

// File: rtl/dgl_edge_det.sv
module dgl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic din_q;
  logic din_n;

  always_comb begin
    din_n = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0;
    end else begin
      din_q <= din_n;
    end
  end

  assign rise = din & ~din_q;

endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
  import dgl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic              load_from_bus,
  output chan_ctrl_t        ctrl_q,
  output logic              pend_q,
  output logic [DATA_W-1:0] code_q,
  output logic              upd_q
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] code_n;
  chan_ctrl_t        ctrl_n;
  logic              pend_n;

  // Next-state logic
  always_comb begin
    ctrl_n = chan_ctrl_t'(wdata[CTRL_W-1:0]);
    code_n = load_from_bus ? wdata : data_q;
    if (dat_we) begin
      // a write survives unless this very load consumed it
      pend_n = !(load && load_from_bus);
    end else if (load) begin
      pend_n = 1'b0;
    end else begin
      pend_n = pend_q;
    end
  end

  // Data register with write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (dat_we) begin
      data_q <= wdata;
    end
  end

  // Control register with write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctl_we) begin
      ctrl_q <= ctrl_n;
    end
  end

  // Output code register with load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= code_n;
    end
  end

  // Pending flag and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      upd_q  <= load;
    end
  end

endmodule

// File: rtl/dgl_update_ctrl.sv
module dgl_update_ctrl
  import dgl_pkg::*;
(
  input  chan_ctrl_t       ctrl0,
  input  chan_ctrl_t       ctrl1,
  input  logic [NCH-1:0]   pend,
  input  logic [NCH-1:0]   dat_we,
  input  logic             trig_rise,
  output logic [NCH-1:0]   load,
  output logic [NCH-1:0]   from_bus,
  output logic             grouped
);

  chan_ctrl_t cs [NCH];
  logic       both_en;
  logic       pend_all;

  function automatic logic solo_load(input chan_ctrl_t c, input logic we,
                                     input logic rise);
    logic r;
    case (c.lsel)
      LSEL_IMM: r = we;
      LSEL_WR:  r = we & c.en;
      default:  r = rise & c.en;
    endcase
    return r;
  endfunction

  always_comb begin
    cs[0]    = ctrl0;
    cs[1]    = ctrl1;
    load     = '0;
    from_bus = '0;
    grouped  = ctrl0.grp && (ctrl0.lsel != LSEL_IMM) && (ctrl1.lsel != LSEL_IMM);
    both_en  = ctrl0.en && ctrl1.en;
    pend_all = (pend[0] | dat_we[0]) && (pend[1] | dat_we[1]);
    if (grouped) begin
      if (both_en) begin
        if (ctrl1.lsel == LSEL_WR) begin
          if ((|dat_we) && pend_all) begin
            load     = '1;
            from_bus = dat_we;
          end
        end else if (trig_rise && (&pend)) begin
          load = '1;
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        load[i]     = solo_load(cs[i], dat_we[i], trig_rise);
        from_bus[i] = dat_we[i] && (cs[i].lsel == LSEL_IMM || cs[i].lsel == LSEL_WR);
      end
    end
  end

endmodule

// File: rtl/dac_group_latch.sv
module dac_group_latch
  import dgl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tmr_trig,
  output logic [DATA_W-1:0] dac0_code,
  output logic [DATA_W-1:0] dac1_code,
  output logic              dac0_upd,
  output logic              dac1_upd
);

  logic [NCH-1:0]    dat_we;
  logic [NCH-1:0]    ctl_we;
  logic [NCH-1:0]    load;
  logic [NCH-1:0]    from_bus;
  logic [NCH-1:0]    pend;
  logic [NCH-1:0]    upd;
  chan_ctrl_t        ctrl [NCH];
  logic [DATA_W-1:0] code [NCH];
  logic              trig_rise;
  logic              grouped;

  // Address decode: bit 1 picks the channel, bit 0 picks control over data.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      dat_we[i] = wr_en && (wr_addr[1] == 1'(i)) && !wr_addr[0];
      ctl_we[i] = wr_en && (wr_addr[1] == 1'(i)) &&  wr_addr[0];
    end
  end

  dgl_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (tmr_trig),
    .rise  (trig_rise)
  );

  dgl_update_ctrl u_ctrl (
    .ctrl0     (ctrl[0]),
    .ctrl1     (ctrl[1]),
    .pend      (pend),
    .dat_we    (dat_we),
    .trig_rise (trig_rise),
    .load      (load),
    .from_bus  (from_bus),
    .grouped   (grouped)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    dgl_chan #(.DATA_W(DATA_W)) u_ch (
      .clk           (clk),
      .rst_n         (rst_n),
      .dat_we        (dat_we[gi]),
      .ctl_we        (ctl_we[gi]),
      .wdata         (wr_data),
      .load          (load[gi]),
      .load_from_bus (from_bus[gi]),
      .ctrl_q        (ctrl[gi]),
      .pend_q        (pend[gi]),
      .code_q        (code[gi]),
      .upd_q         (upd[gi])
    );
  end

  assign dac0_code = code[0];
  assign dac1_code = code[1];
  assign dac0_upd  = upd[0];
  assign dac1_upd  = upd[1];

endmodule

// File: rtl/dgl_checker.sv
module dgl_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] dac0_code,
  input logic [DATA_W-1:0] dac1_code,
  input logic              dac0_upd,
  input logic              dac1_upd,
  input logic              grouped,
  input logic              en0,
  input logic              en1,
  input logic [1:0]        lsel0,
  input logic [1:0]        lsel1,
  input logic [1:0]        pend
);

  assert_group_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grouped |=> (dac0_upd == dac1_upd));

  assert_code0_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac0_code) |-> dac0_upd);

  assert_code1_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac1_code) |-> dac1_upd);

  assert_group_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grouped && !(en0 && en1)) |=> (!dac0_upd && !dac1_upd));

  assert_group_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grouped && !(&pend) && !wr_en) |=> (!dac0_upd && !dac1_upd));

  assert_imm_ch0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsel0 == 2'd0 && wr_en && wr_addr == 2'd0)
      |=> (dac0_upd && dac0_code == $past(wr_data)));

  assert_imm_ch1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsel1 == 2'd0 && wr_en && wr_addr == 2'd2)
      |=> (dac1_upd && dac1_code == $past(wr_data)));

endmodule

bind dac_group_latch dgl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .dac0_code (dac0_code),
  .dac1_code (dac1_code),
  .dac0_upd  (dac0_upd),
  .dac1_upd  (dac1_upd),
  .grouped   (grouped),
  .en0       (ctrl[0].en),
  .en1       (ctrl[1].en),
  .lsel0     (ctrl[0].lsel),
  .lsel1     (ctrl[1].lsel),
  .pend      (pend)
);

// File: tb/tb_dac_group_latch.sv
module tb_dac_group_latch;

  localparam int DW = 12;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic          tmr_trig;
  logic [DW-1:0] dac0_code;
  logic [DW-1:0] dac1_code;
  logic          dac0_upd;
  logic          dac1_upd;

  int n_cmp;
  int n_err;
  bit done;

  // Reference state built from the requirements
  logic [DW-1:0] m_dat  [2];
  logic [3:0]    m_ctl  [2];
  logic          m_pend [2];
  logic [DW-1:0] m_code [2];
  logic          m_upd  [2];
  logic          m_tq;
  string         m_tag  [2];

  dac_group_latch #(.DATA_W(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tmr_trig  (tmr_trig),
    .dac0_code (dac0_code),
    .dac1_code (dac1_code),
    .dac0_upd  (dac0_upd),
    .dac1_upd  (dac1_upd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check({m_tag[0], " dac0_code"}, 32'(dac0_code), 32'(m_code[0]));
    check({m_tag[1], " dac1_code"}, 32'(dac1_code), 32'(m_code[1]));
    check("R11 dac0_upd", 32'(dac0_upd), 32'(m_upd[0]));
    check("R11 dac1_upd", 32'(dac1_upd), 32'(m_upd[1]));
  endtask

  // Evaluate one clock of the reference for the inputs being driven.
  task automatic model_step(input logic we, input logic [1:0] a,
                            input logic [DW-1:0] d, input logic trg);
    logic rise, grp, both_en, pend_all;
    logic dw [2];
    logic cw [2];
    logic ld [2];
    logic fb [2];
    rise = trg && !m_tq;
    for (int i = 0; i < 2; i++) begin
      dw[i] = we && (a[1] == 1'(i)) && !a[0];
      cw[i] = we && (a[1] == 1'(i)) &&  a[0];
      ld[i] = 1'b0;
      fb[i] = 1'b0;
    end
    // R5: grouping from channel 0 group bit and both selects nonzero
    grp      = m_ctl[0][1] && (m_ctl[0][3:2] != 2'd0) && (m_ctl[1][3:2] != 2'd0);
    both_en  = m_ctl[0][0] && m_ctl[1][0];
    pend_all = (m_pend[0] || dw[0]) && (m_pend[1] || dw[1]);
    if (grp) begin
      for (int i = 0; i < 2; i++)
        m_tag[i] = !both_en ? "R7 R5" : (m_ctl[1][3:2] == 2'd1 ? "R9 R6 R8" : "R10 R6 R8");
      if (both_en) begin
        if (m_ctl[1][3:2] == 2'd1) begin
          if ((dw[0] || dw[1]) && pend_all) begin
            ld[0] = 1'b1; ld[1] = 1'b1; fb[0] = dw[0]; fb[1] = dw[1];
          end
        end else if (rise && m_pend[0] && m_pend[1]) begin
          ld[0] = 1'b1; ld[1] = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        case (m_ctl[i][3:2])
          2'd0: begin ld[i] = dw[i]; fb[i] = 1'b1; m_tag[i] = "R2"; end
          2'd1: begin ld[i] = dw[i] && m_ctl[i][0]; fb[i] = 1'b1; m_tag[i] = "R3"; end
          default: begin ld[i] = rise && m_ctl[i][0]; m_tag[i] = "R4"; end
        endcase
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (ld[i]) m_code[i] = fb[i] ? d : m_dat[i];
      m_upd[i] = ld[i];
      if (dw[i]) m_pend[i] = !(ld[i] && fb[i]);
      else if (ld[i]) m_pend[i] = 1'b0;
      if (dw[i]) m_dat[i] = d;
      if (cw[i]) m_ctl[i] = d[3:0];
    end
    m_tq = trg;
  endtask

  task automatic step(input logic we, input logic [1:0] a,
                      input logic [DW-1:0] d, input logic trg);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tmr_trig = trg;
    model_step(we, a, d, trg);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tmr_trig = 1'b0;
    for (int i = 0; i < 2; i++) begin
      m_dat[i] = '0; m_ctl[i] = '0; m_pend[i] = 1'b0;
      m_code[i] = '0; m_upd[i] = 1'b0; m_tag[i] = "R1";
    end
    m_tq = 1'b0;
    #1;
    check("R1 reset dac0_code", 32'(dac0_code), 32'd0);
    check("R1 reset dac1_code", 32'(dac1_code), 32'd0);
    check("R1 reset dac0_upd", 32'(dac0_upd), 32'd0);
    check("R1 reset dac1_upd", 32'(dac1_upd), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] va, vb, vc;
    n_cmp = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tmr_trig = 1'b0;
    // Sweep every pair of control words over one fixed script (R1..R11).
    for (int cfg = 0; cfg < 256; cfg++) begin
      va = DW'((cfg * 37 + 5) & 12'hfff);
      vb = DW'((cfg * 91 + 2048) & 12'hfff);
      vc = DW'((cfg * 13 + 777) & 12'hfff);
      do_reset();
      step(1'b1, 2'd1, DW'(cfg & 15), 1'b0);        // R1 channel 0 control
      step(1'b1, 2'd3, DW'((cfg >> 4) & 15), 1'b0); // R5 channel 1 control
      step(1'b1, 2'd0, va, 1'b0);                   // first write
      step(1'b0, 2'd0, '0, 1'b1);                   // R10 early trigger dropped
      step(1'b0, 2'd0, '0, 1'b0);
      step(1'b1, 2'd2, vb, 1'b0);                   // R9 second write completes
      step(1'b0, 2'd0, '0, 1'b0);                   // R10 no queued trigger
      step(1'b0, 2'd0, '0, 1'b1);                   // R4 rising edge
      step(1'b0, 2'd0, '0, 1'b1);                   // R4 held high, no repeat
      step(1'b0, 2'd0, '0, 1'b0);
      step(1'b1, 2'd0, va, 1'b0);                   // R8 same value rewrite
      step(1'b1, 2'd2, vc, 1'b1);                   // write with trigger edge
      step(1'b0, 2'd0, '0, 1'b0);
      step(1'b0, 2'd0, '0, 1'b1);                   // R10 pending from overlap
      step(1'b1, 2'd3, DW'(((cfg >> 4) & 15) ^ 2), 1'b0); // R5 ch1 group bit flip
      step(1'b1, 2'd2, va ^ vc, 1'b0);
      step(1'b1, 2'd0, vb, 1'b0);
      step(1'b0, 2'd0, '0, 1'b0);
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule